// File: doc/BRIEF.md
# Match Timer with Snapshot Handshake

This block is a 32-bit free-running counter with one compare value. It sits on a simple word-wide register bus. The counter belongs to a slow timer domain. That domain is modelled here by a single-cycle `tick_en` pulse on the bus clock, nominally at 3 MHz.

Three kinds of transfer cross into the timer domain:
- a new compare value,
- a new counter value,
- a request to copy the live counter into a readable holding register.

Each transfer completes only after `SYNC_TICKS` timer ticks. While a transfer is in flight, a dedicated busy bit in the access-status register reads 1, and software polls it.

When the counter meets the compare value on a counting tick, a flag is raised in a write-1-to-clear status register. The flag drives `irq` whenever the interrupt-enable bit is set.

The register bus is a one-beat request channel, qualified by `bus_valid`. `bus_ready` is tied high, so the block never applies back-pressure and every presented beat is accepted in its cycle. Read data returns one cycle after the accepted read, marked by `bus_rvalid`. The response channel has no ready, so the requester must always take it.

Top module: `match_timer`

## Requirements
- R1: After reset these registers read as shown, and `irq` is 0:

  | Register | Reset value |
  |---|---|
  | compare (0x00) | 0xFFFFFFFF |
  | count (0x10) | 0 |
  | status (0x14) | 0 |
  | interrupt enable (0x1C) | 0 |
  | control (0x20) | 0 |
  | access status (0x24) | 0 |
- R2: While control bit 0 is 1, each `tick_en` pulse advances the live counter by one, wrapping from 0xFFFFFFFF to 0. While control bit 0 is 0, the counter holds.
- R3: A write to control (0x20) with bit 1 set requests a snapshot. On the `SYNC_TICKS`-th tick after the request, the count register (0x10) reads back the live value held just before that tick's increment. Control bit 1 always reads 0, and control bit 0 takes the written bit 0.
- R4: Access-status bit 5 reads 1 from the cycle after a snapshot request until the tick that completes it.
- R5: A write to count (0x10) sets access-status bit 4. The written value replaces the live counter on the `SYNC_TICKS`-th tick, and bit 4 then clears.
- R6: A write to compare (0x00) sets access-status bit 0. The value takes effect on the `SYNC_TICKS`-th tick, and bit 0 then clears. Reading 0x00 returns the compare value in effect.
- R7: A compare write, count write or snapshot request made while its own busy bit is 1 is ignored. The ongoing transfer keeps its value and its timing.
- R8: A counting tick on which the live counter equals the compare value sets status bit 0. Status bits 3..1 read 0.
- R9: Writing status (0x14) clears each flag whose written bit is 1 and leaves the others. Status bit 0 is set only on a tick.
- R10: `irq` is 1 exactly when status bit 0 and interrupt-enable bit 0 (0x1C) are both 1.
- R11: `bus_ready` is always 1. `bus_rvalid` is 1 in the cycle after each accepted read. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle timer tick pulse |
| bus_valid | input | 1 | Request beat present |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| irq | output | 1 | Match interrupt |

## Verification
The embedded properties make some assumptions about the inputs:
- reset is asserted before any request;
- `tick_en` may arrive on any cycle;
- the properties do not depend on the spacing between bus beats.

The directed stimulus keeps bus beats and tick pulses in separate cycles. This makes every tick count against a known busy state, so each completion can be predicted exactly. Counter values are preset through the count-write path with counting disabled, so wrap and compare hits land on ticks the bench has counted.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFS_MATCH  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_ASTAT  = 6'h24;
  localparam int BIT_MATCH_BUSY = 0;
  localparam int BIT_CNT_BUSY   = 4;
  localparam int BIT_SNAP_BUSY  = 5;
  localparam int N_XFER = 3;
  localparam int XF_MATCH = 0;
  localparam int XF_COUNT = 1;
  localparam int XF_SNAP  = 2;
endpackage

// File: rtl/mtmr_xfer.sv
module mtmr_xfer #(
  parameter int SYNC_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

  logic [CW-1:0] n_q;

  assign done = busy & tick & (n_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      n_q  <= '0;
    end else if (!busy) begin
      n_q <= '0;
      if (start) busy <= 1'b1;
    end else if (tick) begin
      if (n_q == LAST) busy <= 1'b0;
      else             n_q  <= n_q + 1'b1;
    end
  end

  // R7: a request arriving mid-transfer neither ends nor restarts it
  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);
  // R4: busy only starts from a request
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

// File: rtl/mtmr_core.sv
module mtmr_core #(
  parameter int W  = 32,
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          load_cnt,
  input  logic [W-1:0]  load_val,
  input  logic          load_match,
  input  logic [W-1:0]  match_val,
  input  logic          snap,
  input  logic [NF-1:0] clr_mask,
  output logic [W-1:0]  cnt_q,
  output logic [W-1:0]  match_q,
  output logic [W-1:0]  snap_q,
  output logic [NF-1:0] flags_q
);
  logic          hit;
  logic [NF-1:0] set_vec;

  assign hit     = tick & enable & ~load_cnt & (cnt_q == match_q);
  assign set_vec = {{(NF-1){1'b0}}, hit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_q <= '1;
      snap_q  <= '0;
      flags_q <= '0;
    end else begin
      if (load_cnt)             cnt_q <= load_val;
      else if (tick && enable)  cnt_q <= cnt_q + 1'b1;
      if (load_match) match_q <= match_val;
      if (snap)       snap_q  <= cnt_q;
      flags_q <= (flags_q & ~clr_mask) | set_vec;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && enable) && !load_cnt) |=> $stable(cnt_q));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable && !load_cnt) |=> cnt_q == $past(cnt_q) + W'(1));
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable && !load_cnt && cnt_q == match_q) |=> flags_q[0]);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SYNC_TICKS = 2,
  parameter int N_FLAGS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic wr, rd;
  logic [N_XFER-1:0] xf_start, xf_busy, xf_done;
  logic [DATA_W-1:0] pend_cnt, pend_match;
  logic ctrl_en, ien_q;
  logic [N_FLAGS-1:0] clr_mask, flags;
  logic [DATA_W-1:0] cnt_q, match_q, snap_q, astat, rd_mux;

  assign bus_ready = 1'b1;
  assign wr = bus_valid & bus_write;
  assign rd = bus_valid & ~bus_write;

  assign xf_start[XF_MATCH] = wr & (bus_addr == OFS_MATCH);
  assign xf_start[XF_COUNT] = wr & (bus_addr == OFS_COUNT);
  assign xf_start[XF_SNAP]  = wr & (bus_addr == OFS_CTRL) & bus_wdata[1];

  for (genvar i = 0; i < N_XFER; i++) begin : g_xfer
    mtmr_xfer #(.SYNC_TICKS(SYNC_TICKS)) u_xf (
      .clk(clk), .rst_n(rst_n), .tick(tick_en),
      .start(xf_start[i]), .busy(xf_busy[i]), .done(xf_done[i])
    );
  end

  assign clr_mask = (wr && bus_addr == OFS_STATUS) ? bus_wdata[N_FLAGS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cnt   <= '0;
      pend_match <= '1;
      ctrl_en    <= 1'b0;
      ien_q      <= 1'b0;
    end else begin
      if (xf_start[XF_COUNT] && !xf_busy[XF_COUNT]) pend_cnt   <= bus_wdata;
      if (xf_start[XF_MATCH] && !xf_busy[XF_MATCH]) pend_match <= bus_wdata;
      if (wr && bus_addr == OFS_CTRL) ctrl_en <= bus_wdata[0];
      if (wr && bus_addr == OFS_IEN)  ien_q   <= bus_wdata[0];
    end
  end

  mtmr_core #(.W(DATA_W), .NF(N_FLAGS)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .enable(ctrl_en),
    .load_cnt(xf_done[XF_COUNT]), .load_val(pend_cnt),
    .load_match(xf_done[XF_MATCH]), .match_val(pend_match),
    .snap(xf_done[XF_SNAP]), .clr_mask(clr_mask),
    .cnt_q(cnt_q), .match_q(match_q), .snap_q(snap_q), .flags_q(flags)
  );

  always_comb begin
    astat = '0;
    astat[BIT_MATCH_BUSY] = xf_busy[XF_MATCH];
    astat[BIT_CNT_BUSY]   = xf_busy[XF_COUNT];
    astat[BIT_SNAP_BUSY]  = xf_busy[XF_SNAP];
  end

  always_comb begin
    case (bus_addr)
      OFS_MATCH:  rd_mux = match_q;
      OFS_COUNT:  rd_mux = snap_q;
      OFS_STATUS: rd_mux = DATA_W'(flags);
      OFS_IEN:    rd_mux = DATA_W'(ien_q);
      OFS_CTRL:   rd_mux = DATA_W'(ctrl_en);
      OFS_ASTAT:  rd_mux = astat;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  assign irq = flags[0] & ien_q;

  a_r11_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);
  a_r9_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(tick_en));
endmodule

// File: tb/sim_match_timer.sv
module sim_match_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, bus_rvalid, irq;
  logic [31:0] bus_rdata;
  int errors = 0, checks = 0, cycles = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  match_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
    check("R11 rvalid", {31'b0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1; @(posedge clk); @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic t_reset();
    rd(6'h00, v); check("R1 match", v, 32'hFFFFFFFF);
    rd(6'h10, v); check("R1 count", v, 32'h0);
    rd(6'h14, v); check("R1 status", v, 32'h0);
    rd(6'h1C, v); check("R1 ien", v, 32'h0);
    rd(6'h20, v); check("R1 ctrl", v, 32'h0);
    rd(6'h24, v); check("R1 astat", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R11 ready", {31'b0, bus_ready}, 32'd1);
    rd(6'h08, v); check("R11 unmapped", v, 32'h0);
  endtask

  task automatic t_load_and_snap();
    wr(6'h10, 32'h100);
    rd(6'h24, v); check("R5 cnt busy", v, 32'h10);
    ticks(1);
    rd(6'h24, v); check("R5 cnt busy after 1 tick", v, 32'h10);
    ticks(1);
    rd(6'h24, v); check("R5 cnt busy cleared", v, 32'h0);
    wr(6'h20, 32'h2);
    rd(6'h24, v); check("R4 snap busy", v, 32'h20);
    rd(6'h20, v); check("R3 ctrl bit1 reads 0", v, 32'h0);
    ticks(2);
    rd(6'h24, v); check("R4 snap busy cleared", v, 32'h0);
    rd(6'h10, v); check("R3 R2 snapshot held count", v, 32'h100);
  endtask

  task automatic t_counting();
    wr(6'h20, 32'h3);
    ticks(2);
    rd(6'h10, v); check("R3 snapshot while counting", v, 32'h101);
    rd(6'h20, v); check("R3 ctrl enable kept", v, 32'h1);
    ticks(5);
    wr(6'h20, 32'h3);
    ticks(1);
    wr(6'h20, 32'h3);
    ticks(1);
    rd(6'h24, v); check("R7 snap request ignored", v, 32'h0);
    rd(6'h10, v); check("R2 R3 count advanced", v, 32'h108);
  endtask

  task automatic t_match_ignore();
    wr(6'h00, 32'h200);
    rd(6'h24, v); check("R6 match busy", v, 32'h1);
    wr(6'h00, 32'h300);
    rd(6'h00, v); check("R6 old match still in effect", v, 32'hFFFFFFFF);
    ticks(2);
    rd(6'h24, v); check("R6 match busy cleared", v, 32'h0);
    rd(6'h00, v); check("R7 second match ignored", v, 32'h200);
  endtask

  task automatic t_hit_irq();
    wr(6'h20, 32'h0);
    wr(6'h10, 32'h1FD);
    ticks(2);
    wr(6'h1C, 32'h1);
    rd(6'h1C, v); check("R10 ien readback", v, 32'h1);
    wr(6'h20, 32'h1);
    ticks(3);
    rd(6'h14, v); check("R8 no flag before match", v, 32'h0);
    check("R10 irq low", {31'b0, irq}, 32'd0);
    ticks(1);
    rd(6'h14, v); check("R8 flag on match", v, 32'h1);
    check("R10 irq high", {31'b0, irq}, 32'd1);
  endtask

  task automatic t_w1c();
    wr(6'h14, 32'h0);
    rd(6'h14, v); check("R9 zero write keeps flag", v, 32'h1);
    wr(6'h14, 32'hE);
    rd(6'h14, v); check("R9 other bits keep flag", v, 32'h1);
    wr(6'h14, 32'h1);
    rd(6'h14, v); check("R9 flag cleared", v, 32'h0);
    check("R10 irq after clear", {31'b0, irq}, 32'd0);
  endtask

  task automatic t_wrap_mask();
    wr(6'h20, 32'h0);
    wr(6'h1C, 32'h0);
    wr(6'h10, 32'hFFFFFFFE);
    wr(6'h00, 32'h0);
    ticks(2);
    wr(6'h20, 32'h1);
    ticks(2);
    rd(6'h14, v); check("R8 no flag before wrap", v, 32'h0);
    ticks(1);
    rd(6'h14, v); check("R8 flag at zero after wrap", v, 32'h1);
    check("R10 masked irq", {31'b0, irq}, 32'd0);
    wr(6'h20, 32'h3);
    ticks(2);
    rd(6'h10, v); check("R2 wrapped count", v, 32'h2);
    wr(6'h1C, 32'h1);
    check("R10 unmask raises irq", {31'b0, irq}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_and_snap();
    t_counting();
    t_match_ignore();
    t_hit_irq();
    t_w1c();
    t_wrap_mask();
    finish_run();
  end
endmodule